// File: doc/BRIEF.md
# SD Host Data-Path Suspend Controller

This block is the data-side sequencer of an SD host controller. It follows single-block and multi-block transfers in either direction and can bring a multi-block transfer to an orderly halt on a block boundary, so that another transfer can use the bus. The transfer can later be picked up again from the next unsent block. The data-line activity is abstracted into one-cycle event inputs: one marks the end of a block's data phase and one marks the arrival of a write CRC status token. The command side is abstracted to a send strobe carrying a "this is a suspend" flag, and a response strobe carrying an "accepted" flag.

A small tracker remembers whether the last command sent was a suspend request. It forwards an acknowledgment only when the response to that command accepts the suspend. A write that receives the acknowledgment finishes the block in flight and stops once that block's CRC token has arrived. A read that receives it finishes the block being received and then waits in a drain state until the host reports that the receive FIFO is empty. Only then does it go idle. In both cases the remaining block count and the direction are saved, and a suspended flag is raised. A resume strobe restores the saved context. An unrelated transfer may run between the suspend and the resume.

Top module: `sdx_suspend_dpath`

## Requirements
- R1: In idle, `xfer_start` with a nonzero `xfer_blocks` loads `blocks_left` and leaves idle on the next cycle. `xfer_dir`=1 selects a write (`dp_writing`=1) and 0 selects a read. A start with zero blocks, or a start while a transfer is active, is ignored.
- R2: `blocks_left` drops by one per completed block. A write block completes on `crc_tok` and a read block completes on `blk_done`. When the count reaches zero the block returns to idle, pulses `xfer_done` for one cycle and leaves `dp_suspended` low.
- R3: An acknowledgment arises only when `cmd_send` with `cmd_susp`=1 is followed by `cmd_resp` with `cmd_accept`=1. A rejected suspend, or an accepted response to a command sent with `cmd_susp`=0, leaves the transfer running to completion.
- R4: An acknowledged suspend during a write goes idle right after the CRC token of the current block. It sets `dp_suspended`, and `blocks_left` equals the blocks not yet transferred.
- R5: An acknowledged suspend during a read enters the drain state (`rx_drain`=1) when the current block completes. The block holds the drain state while `fifo_empty`=0 and then goes idle with `dp_suspended`=1.
- R6: A suspend acknowledged during the final block does not suspend. The transfer completes as in R2.
- R7: An acknowledgment that arrives while idle is ignored: `dp_suspended` stays low.
- R8: While suspended, a fresh transfer may run to completion, and `dp_suspended` stays high throughout.
- R9: `resume_req` in idle with `dp_suspended`=1 clears the flag, restores the saved direction and remaining count, and restarts the transfer. It takes priority over `xfer_start`. `resume_req` while not suspended is ignored.
- R10: After reset the block is idle, with `dp_suspended`, `rx_drain`, `dp_writing` and `xfer_done` low and `blocks_left`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Start a new transfer (pulse) |
| xfer_dir | input | 1 | 1 = write to card, 0 = read from card |
| xfer_blocks | input | CNT_W | Number of blocks for the new transfer |
| resume_req | input | 1 | Resume the suspended transfer (pulse) |
| cmd_send | input | 1 | A command is issued (pulse) |
| cmd_susp | input | 1 | The issued command is a suspend request |
| cmd_resp | input | 1 | Response received (pulse) |
| cmd_accept | input | 1 | The response accepts a suspend |
| blk_done | input | 1 | Data phase of one block finished (pulse) |
| crc_tok | input | 1 | Write CRC status token received (pulse) |
| fifo_empty | input | 1 | Receive FIFO is empty |
| dp_idle | output | 1 | Data path idle |
| dp_writing | output | 1 | A write transfer is active |
| rx_drain | output | 1 | Read halted, waiting for the host to empty the FIFO |
| dp_suspended | output | 1 | A suspended transfer is saved |
| blocks_left | output | CNT_W | Blocks remaining in the active transfer |
| xfer_done | output | 1 | Transfer completed (one-cycle pulse) |

## Verification
The assertions take for granted that every event input is a single-cycle pulse. They also assume that `blk_done` arrives only while a block is being sent or received, that `crc_tok` arrives only while a write awaits its token, and that a response follows the command it answers. The stimulus keeps within this by driving each event from a task that leaves idle cycles after the pulse. Suspend commands are always issued inside the block they are meant to stop, and a start and a resume never share a cycle except where R9's priority is under test.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WSEND = 3'd1,
      ST_WCRC  = 3'd2,
      ST_RRECV = 3'd3,
      ST_RWAIT = 3'd4
   } dp_state_e;
endpackage

// File: rtl/sdx_susp_track.sv
module sdx_susp_track (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_send,
   input  logic cmd_susp,
   input  logic cmd_resp,
   input  logic cmd_accept,
   output logic susp_ack
);
   logic armed_q;

   // armed_q remembers whether the outstanding command asked for a suspend
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         susp_ack <= 1'b0;
      end else begin
         susp_ack <= cmd_resp & cmd_accept & armed_q;
         if (cmd_send)
            armed_q <= cmd_susp;
         else if (cmd_resp)
            armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sdx_fe_sync.sv
module sdx_fe_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fe_in,
   output logic fe_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign fe_out = fe_in;
      end else begin : g_sync
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[0] <= 1'b1;
            else        sh_q[0] <= fe_in;
         end
         for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh_q[g] <= 1'b1;
               else        sh_q[g] <= sh_q[g-1];
            end
         end
         assign fe_out = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sdx_blk_ctx.sv
module sdx_blk_ctx #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             load_wr,
   input  logic             dec,
   input  logic             save,
   input  logic             restore,
   output logic [CNT_W-1:0] cnt,
   output logic             last,
   output logic             saved_wr
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, saved_q, cnt_m1;
   logic             swr_q;

   assign cnt_m1   = cnt_q - ONE;
   assign cnt      = cnt_q;
   assign last     = (cnt_q == ONE);
   assign saved_wr = swr_q;

   // saving always coincides with a block completion, so the saved
   // count is the value after that block is retired
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         saved_q <= '0;
         swr_q   <= 1'b0;
      end else begin
         if (restore)   cnt_q <= saved_q;
         else if (load) cnt_q <= load_cnt;
         else if (dec)  cnt_q <= cnt_m1;
         if (save) begin
            saved_q <= cnt_m1;
            swr_q   <= load_wr;
         end
      end
   end
endmodule

// File: rtl/sdx_dp_fsm.sv
module sdx_dp_fsm
   import sdx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_ok,
   input  logic start_wr,
   input  logic resume_req,
   input  logic susp_ack,
   input  logic blk_done,
   input  logic crc_tok,
   input  logic fe,
   input  logic last,
   input  logic saved_wr,
   output logic ld,
   output logic dec,
   output logic sav,
   output logic rst_ctx,
   output logic cur_wr,
   output dp_state_e state,
   output logic suspended,
   output logic done
);
   dp_state_e st_q, st_d;
   logic pend_q, pend_eff, set_susp, clr_susp, done_d;

   assign pend_eff = pend_q | susp_ack;
   assign state    = st_q;
   assign cur_wr   = (st_q == ST_WSEND) || (st_q == ST_WCRC);

   always_comb begin
      st_d     = st_q;
      ld       = 1'b0;
      dec      = 1'b0;
      sav      = 1'b0;
      rst_ctx  = 1'b0;
      set_susp = 1'b0;
      clr_susp = 1'b0;
      done_d   = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (resume_req && suspended) begin
               rst_ctx  = 1'b1;
               clr_susp = 1'b1;
               st_d     = saved_wr ? ST_WSEND : ST_RRECV;
            end else if (start_ok) begin
               ld   = 1'b1;
               st_d = start_wr ? ST_WSEND : ST_RRECV;
            end
         end
         ST_WSEND: if (blk_done) st_d = ST_WCRC;
         ST_WCRC: begin
            if (crc_tok) begin
               dec = 1'b1;
               if (last) begin
                  st_d   = ST_IDLE;
                  done_d = 1'b1;
               end else if (pend_eff) begin
                  sav      = 1'b1;
                  set_susp = 1'b1;
                  st_d     = ST_IDLE;
               end else begin
                  st_d = ST_WSEND;
               end
            end
         end
         ST_RRECV: begin
            if (blk_done) begin
               dec = 1'b1;
               if (last) begin
                  st_d   = ST_IDLE;
                  done_d = 1'b1;
               end else if (pend_eff) begin
                  sav  = 1'b1;
                  st_d = ST_RWAIT;
               end
            end
         end
         ST_RWAIT: begin
            if (fe) begin
               set_susp = 1'b1;
               st_d     = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         pend_q    <= 1'b0;
         suspended <= 1'b0;
         done      <= 1'b0;
      end else begin
         st_q   <= st_d;
         done   <= done_d;
         // a pending suspend survives only inside one running transfer
         pend_q <= pend_eff && (st_q != ST_IDLE) && (st_q != ST_RWAIT) &&
                   (st_d != ST_IDLE) && (st_d != ST_RWAIT);
         if (set_susp)      suspended <= 1'b1;
         else if (clr_susp) suspended <= 1'b0;
      end
   end
endmodule

// File: rtl/sdx_suspend_dpath.sv
module sdx_suspend_dpath
   import sdx_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int FE_SYNC = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_start,
   input  logic             xfer_dir,
   input  logic [CNT_W-1:0] xfer_blocks,
   input  logic             resume_req,
   input  logic             cmd_send,
   input  logic             cmd_susp,
   input  logic             cmd_resp,
   input  logic             cmd_accept,
   input  logic             blk_done,
   input  logic             crc_tok,
   input  logic             fifo_empty,
   output logic             dp_idle,
   output logic             dp_writing,
   output logic             rx_drain,
   output logic             dp_suspended,
   output logic [CNT_W-1:0] blocks_left,
   output logic             xfer_done
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("sdx_suspend_dpath: CNT_W must be 2..16");
      end
      if (FE_SYNC < 0 || FE_SYNC > 3) begin : g_bad_sync
         $error("sdx_suspend_dpath: FE_SYNC must be 0..3");
      end
   endgenerate

   logic      susp_ack, fe_eff, last, saved_wr, cur_wr;
   logic      ld, dec, sav, rst_ctx, start_ok;
   dp_state_e state;

   assign start_ok = xfer_start && (xfer_blocks != '0);

   sdx_susp_track u_trk (
      .clk(clk), .rst_n(rst_n), .cmd_send(cmd_send), .cmd_susp(cmd_susp),
      .cmd_resp(cmd_resp), .cmd_accept(cmd_accept), .susp_ack(susp_ack)
   );

   sdx_fe_sync #(.STAGES(FE_SYNC)) u_fes (
      .clk(clk), .rst_n(rst_n), .fe_in(fifo_empty), .fe_out(fe_eff)
   );

   sdx_blk_ctx #(.CNT_W(CNT_W)) u_ctx (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_cnt(xfer_blocks),
      .load_wr(cur_wr), .dec(dec), .save(sav), .restore(rst_ctx),
      .cnt(blocks_left), .last(last), .saved_wr(saved_wr)
   );

   sdx_dp_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .start_wr(xfer_dir),
      .resume_req(resume_req), .susp_ack(susp_ack), .blk_done(blk_done),
      .crc_tok(crc_tok), .fe(fe_eff), .last(last), .saved_wr(saved_wr),
      .ld(ld), .dec(dec), .sav(sav), .rst_ctx(rst_ctx), .cur_wr(cur_wr),
      .state(state), .suspended(dp_suspended), .done(xfer_done)
   );

   assign dp_idle    = (state == ST_IDLE);
   assign rx_drain   = (state == ST_RWAIT);
   assign dp_writing = cur_wr;
endmodule

// File: rtl/sdx_suspend_dpath_chk.sv
module sdx_suspend_dpath_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xfer_start,
   input logic [CNT_W-1:0] xfer_blocks,
   input logic             resume_req,
   input logic             susp_ack,
   input logic             fe_eff,
   input logic             dp_idle,
   input logic             dp_writing,
   input logic             rx_drain,
   input logic             dp_suspended,
   input logic [CNT_W-1:0] blocks_left,
   input logic             xfer_done
);
   a_r1_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_idle && xfer_start && xfer_blocks != '0 && !(resume_req && dp_suspended))
      |=> (!dp_idle && blocks_left == $past(xfer_blocks)));

   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (dp_idle && blocks_left == '0 && !rx_drain));

   a_r4_write_stop: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dp_suspended) && !$past(rx_drain)) |-> $past(dp_writing));

   a_r5_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_drain && !fe_eff) |=> rx_drain);

   a_r5_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_drain && fe_eff) |=> (dp_idle && dp_suspended));

   a_r7_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_idle && susp_ack && !dp_suspended) |=> !dp_suspended);

   a_r8_susp_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_suspended && !(dp_idle && resume_req)) |=> dp_suspended);

   a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_idle && dp_suspended && resume_req) |=> (!dp_idle && !dp_suspended));

   a_r9_no_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_idle && !dp_suspended && resume_req && !xfer_start) |=> dp_idle);
endmodule

bind sdx_suspend_dpath sdx_suspend_dpath_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_blocks(xfer_blocks),
   .resume_req(resume_req), .susp_ack(susp_ack), .fe_eff(fe_eff),
   .dp_idle(dp_idle), .dp_writing(dp_writing), .rx_drain(rx_drain),
   .dp_suspended(dp_suspended), .blocks_left(blocks_left), .xfer_done(xfer_done)
);

// File: tb/sdx_suspend_dpath_test.sv
module sdx_suspend_dpath_test;
   localparam int CW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic xfer_start = 0, xfer_dir = 0, resume_req = 0;
   logic [CW-1:0] xfer_blocks = '0;
   logic cmd_send = 0, cmd_susp = 0, cmd_resp = 0, cmd_accept = 0;
   logic blk_done = 0, crc_tok = 0, fifo_empty = 1;
   logic dp_idle, dp_writing, rx_drain, dp_suspended, xfer_done;
   logic [CW-1:0] blocks_left;

   int n_chk = 0, n_bad = 0, done_cnt = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sdx_suspend_dpath #(.CNT_W(CW), .FE_SYNC(0)) uut (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_dir(xfer_dir),
      .xfer_blocks(xfer_blocks), .resume_req(resume_req), .cmd_send(cmd_send),
      .cmd_susp(cmd_susp), .cmd_resp(cmd_resp), .cmd_accept(cmd_accept),
      .blk_done(blk_done), .crc_tok(crc_tok), .fifo_empty(fifo_empty),
      .dp_idle(dp_idle), .dp_writing(dp_writing), .rx_drain(rx_drain),
      .dp_suspended(dp_suspended), .blocks_left(blocks_left), .xfer_done(xfer_done)
   );

   always @(posedge clk) if (rst_n && xfer_done) done_cnt <= done_cnt + 1;

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_xfer(bit dir, int n);
      xfer_dir = dir; xfer_blocks = CW'(n); xfer_start = 1;
      if (!dir) fifo_empty = 0;
      step(1); xfer_start = 0; step(2);
   endtask

   task automatic do_blk();
      blk_done = 1; step(1); blk_done = 0; step(2);
   endtask

   task automatic do_crc();
      crc_tok = 1; step(1); crc_tok = 0; step(2);
   endtask

   // mode 0: accepted suspend, 1: rejected suspend, 2: accepted plain command
   task automatic do_cmd(int mode);
      cmd_susp = (mode != 2); cmd_send = 1; step(1); cmd_send = 0; step(1);
      cmd_accept = (mode != 1); cmd_resp = 1; step(1); cmd_resp = 0; cmd_accept = 0;
      step(2);
   endtask

   task automatic do_resume();
      resume_req = 1; step(1); resume_req = 0; step(2);
   endtask

   // run blocks first..n of a transfer; k = block carrying the suspend command
   task automatic run_blocks(bit dir, int n, int first, int k, int mode,
                             output bit stopped);
      stopped = 0;
      for (int i = first; i <= n; i++) begin
         int d0 = done_cnt;
         bit acc = (i == k) && (mode == 0);
         if (dir) begin
            do_blk();
            if (i == k) do_cmd(mode);
            do_crc();
         end else begin
            if (i == k) do_cmd(mode);
            do_blk();
         end
         check("R2 blocks_left", blocks_left, n - i);
         if (i == n) begin
            check(acc ? "R6 idle at end" : "R2 idle at end", dp_idle, 1);
            check(acc ? "R6 not suspended" : "R2 not suspended", dp_suspended, 0);
            check("R2 done pulse", done_cnt - d0, 1);
            return;
         end
         if (acc) begin
            if (dir) begin
               check("R4 idle after crc", dp_idle, 1);
               check("R4 suspended", dp_suspended, 1);
            end else begin
               check("R5 in drain", rx_drain, 1);
               check("R5 not idle", dp_idle, 0);
               step(3);
               check("R5 drain holds", rx_drain, 1);
               fifo_empty = 1; step(2);
               check("R5 idle after drain", dp_idle, 1);
               check("R5 suspended", dp_suspended, 1);
            end
            stopped = 1;
            return;
         end
         check(mode != 0 && i >= k ? "R3 still running" : "R2 still running",
               dp_idle, 0);
      end
   endtask

   task automatic run_case(bit dir, int n, int k, int mode);
      bit stopped;
      start_xfer(dir, n);
      check("R1 load count", blocks_left, n);
      check("R1 left idle", dp_idle, 0);
      check("R1 direction", dp_writing, dir);
      run_blocks(dir, n, 1, k, mode, stopped);
      if (stopped) begin
         int d0 = done_cnt;
         // R8 intervening single-block read
         start_xfer(1'b0, 1);
         check("R8 interim started", dp_idle, 0);
         check("R8 flag kept", dp_suspended, 1);
         do_blk();
         check("R8 interim done", dp_idle, 1);
         check("R8 interim pulse", done_cnt - d0, 1);
         check("R8 flag still set", dp_suspended, 1);
         do_resume();
         check("R9 flag cleared", dp_suspended, 0);
         check("R9 saved count", blocks_left, n - k);
         check("R9 saved direction", dp_writing, dir);
         if (!dir) fifo_empty = 0;
         run_blocks(dir, n, k + 1, 0, 0, stopped);
      end
      fifo_empty = 1;
      step(1);
   endtask

   initial begin
      step(3);
      check("R10 idle", dp_idle, 1);
      check("R10 suspended", dp_suspended, 0);
      check("R10 count", blocks_left, 0);
      check("R10 drain", rx_drain, 0);
      check("R10 writing", dp_writing, 0);
      check("R10 done", xfer_done, 0);
      rst_n = 1; step(2);

      // R7: accepted suspend while idle
      do_cmd(0);
      check("R7 stays idle", dp_idle, 1);
      check("R7 no suspend", dp_suspended, 0);
      // R9: resume while not suspended
      do_resume();
      check("R9 resume ignored", dp_idle, 1);
      // R1: zero-count start ignored
      start_xfer(1'b1, 0);
      check("R1 zero start ignored", dp_idle, 1);
      fifo_empty = 1;
      // R1: start while busy ignored
      start_xfer(1'b1, 3);
      start_xfer(1'b0, 5);
      check("R1 busy start ignored", blocks_left, 3);
      check("R1 busy dir kept", dp_writing, 1);
      for (int i = 0; i < 3; i++) begin do_blk(); do_crc(); end
      check("R1 finished", dp_idle, 1);
      fifo_empty = 1;

      // sweep direction, length, suspend point, command outcome
      for (int dir = 0; dir < 2; dir++)
         for (int n = 1; n <= 6; n++)
            for (int k = 0; k <= n; k++)
               for (int mode = 0; mode < 3; mode++)
                  if (mode == 0 || k == 1) run_case(dir[0], n, k, mode);

      // R9: resume wins over a simultaneous start
      start_xfer(1'b1, 4);
      do_blk(); do_cmd(0); do_crc();
      check("R4 directed suspend", dp_suspended, 1);
      xfer_dir = 0; xfer_blocks = CW'(7); xfer_start = 1; resume_req = 1;
      step(1); xfer_start = 0; resume_req = 0; step(2);
      check("R9 priority count", blocks_left, 3);
      check("R9 priority dir", dp_writing, 1);
      wrap_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      wrap_up();
   end
endmodule